// File: doc/BRIEF.md
# NAND Host Bus Bridge

The bridge connects a 16-bit register-mapped host bus to a raw 8-bit NAND device. The host writes a byte-wide mode register whose bits drive the chip enable, command latch and address latch lines. Each host access to the data window becomes one or two NAND byte cycles. A byte cycle strobes write-enable or read-enable low for a fixed number of clocks. A 16-bit access moves two NAND bytes, with the first byte in the low half of the word. The host is stalled on a wait line until the byte cycles have finished.

The NAND ready/busy line is synchronised. It is visible to the host as a busy flag in the status register. Its rising edge latches a ready event in an interrupt status register, and an interrupt mask register gates that event onto the interrupt output. Once reset is released, the bridge issues a reset command to the device on its own and then leaves the device in standby.

Top module: `nand_bridge`

## Requirements
- R1: After reset is released, the bridge performs exactly one NAND write of byte 0xFF with chip enable active, CLE high and ALE low. It then rests in standby with nand_ce_no high and CLE and ALE low.
- R2: The mode register is at offset 4 and reads back what was written. Bit 4 makes the chip enable active, bit 0 drives CLE and bit 1 drives ALE. So 0x95 selects command latch, 0x96 selects address latch, 0x94 selects plain data and 0x00 selects standby. Register accesses use byte lane 7:0 only.
- R3: A narrow (8-bit) write to the data window (offsets 0 to 3) drives the byte on nand_dq_o. Write-enable is pulsed low for exactly STROBE_CYC clocks, and CLE and ALE stay stable while it is low.
- R4: A wide (16-bit) data write performs two NAND writes: bits 7:0 first, then bits 15:8.
- R5: A wide data read performs two read-enable pulses of STROBE_CYC clocks each. The first byte is returned in bits 15:0's low byte and the second in bits 15:8. A narrow read returns one byte in bits 7:0, with bits 15:8 zero.
- R6: Bit 7 of the status register at offset 5 reads 1 while nand_rb_i is low (busy) and 0 when it is high. All other status bits read 0.
- R7: A rising edge of nand_rb_i sets bit 0 of the interrupt status register at offset 6. A falling edge, or a steady level, sets nothing.
- R8: Writing a 1 to any of bits 3:0 of the interrupt status register clears that bit, so writing 0x0F clears all pending events.
- R9: irq_o is high when mask bit 7 is set and some pending status bit in 3:0 also has its mask bit set. Writing 0x81 to the mask at offset 7 enables the ready interrupt, and 0x00 disables it. The output stays high until the status is cleared or the mask is removed.
- R10: host_wait_o is high during a data-window access until its byte cycles are done. A register access completes with host_wait_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Access request, held until wait is low |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_wide_i | input | 1 | 1 = 16-bit data access, 0 = 8-bit |
| host_addr_i | input | 3 | Byte offset |
| host_wdata_i | input | 16 | Write data |
| host_rdata_o | output | 16 | Read data, valid while wait is low |
| host_wait_o | output | 1 | Stall the current access |
| irq_o | output | 1 | Ready interrupt |
| nand_ce_no | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write enable, active low |
| nand_re_no | output | 1 | Read enable, active low |
| nand_dq_o | output | 8 | NAND data out |
| nand_dq_oe_o | output | 1 | NAND data output enable |
| nand_dq_i | input | 8 | NAND data in |
| nand_rb_i | input | 1 | Ready/busy, 1 = ready |

## Verification
The byte path is exercised with narrow and wide writes under command, address and data modes. This separates lane order from the latch strobes: a swapped lane shows up as 0xBE before 0xEF. The read path is driven by a device model that returns a distinct byte per read-enable pulse. This exposes both lane order and an off-by-one in the sampling point. The ready line is toggled low and then high under different mask values, which distinguishes edge latching from level latching and separates the global mask bit from the per-event bit.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;
  localparam logic [2:0] OFS_MODE   = 3'd4;
  localparam logic [2:0] OFS_STATUS = 3'd5;
  localparam logic [2:0] OFS_ISR    = 3'd6;
  localparam logic [2:0] OFS_MASK   = 3'd7;

  typedef enum logic [1:0] {ENG_IDLE, ENG_SETUP, ENG_PULSE, ENG_HOLD} eng_st_e;
  typedef enum logic [2:0] {T_IDLE, T_INIT, T_BYTE0, T_BYTE1, T_DONE} top_st_e;
endpackage

// File: rtl/nand_byte_engine.sv
module nand_byte_engine
  import nand_bridge_pkg::*;
#(
  parameter int STROBE_CYC = 3,
  localparam int CNT_W = $clog2(STROBE_CYC + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       wr_i,
  input  logic [7:0] wbyte_i,
  output logic       done_o,
  output logic [7:0] rbyte_o,
  output logic       we_no,
  output logic       re_no,
  output logic [7:0] dq_o,
  output logic       dq_oe_o,
  input  logic [7:0] dq_i
);
  eng_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_q;
  logic [7:0]       dq_q, rbyte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ENG_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      dq_q    <= '0;
      rbyte_q <= '0;
    end else begin
      unique case (st_q)
        ENG_IDLE, ENG_HOLD: begin
          if (start_i) begin
            st_q <= ENG_SETUP;
            wr_q <= wr_i;
            dq_q <= wbyte_i;
          end else begin
            st_q <= ENG_IDLE;
          end
        end
        ENG_SETUP: begin
          st_q  <= ENG_PULSE;
          cnt_q <= '0;
        end
        ENG_PULSE: begin
          if (cnt_q == CNT_W'(STROBE_CYC - 1)) begin
            st_q <= ENG_HOLD;
            if (!wr_q) rbyte_q <= dq_i;  // sampled as re rises
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

  assign done_o  = (st_q == ENG_HOLD);
  assign rbyte_o = rbyte_q;
  assign we_no   = !((st_q == ENG_PULSE) && wr_q);
  assign re_no   = !((st_q == ENG_PULSE) && !wr_q);
  assign dq_o    = dq_q;
  assign dq_oe_o = wr_q && (st_q != ENG_IDLE);
endmodule

// File: rtl/nand_irq_ctrl.sv
module nand_irq_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int EVT_BITS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rb_i,
  input  logic       isr_we_i,
  input  logic       mask_we_i,
  input  logic [7:0] wbyte_i,
  output logic       busy_o,
  output logic [7:0] isr_o,
  output logic [7:0] mask_o,
  output logic       irq_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rb_prev_q;
  logic [EVT_BITS-1:0]    isr_q;
  logic [7:0]             mask_q;
  logic [EVT_BITS-1:0]    evt_set;

  // reset to ready so a high line after reset is no edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q    <= '1;
      rb_prev_q <= 1'b1;
    end else begin
      sync_q    <= {sync_q[SYNC_STAGES-2:0], rb_i};
      rb_prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  always_comb begin
    evt_set    = '0;
    evt_set[0] = sync_q[SYNC_STAGES-1] & ~rb_prev_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q  <= '0;
      mask_q <= '0;
    end else begin
      if (isr_we_i) isr_q <= (isr_q & ~wbyte_i[EVT_BITS-1:0]) | evt_set;
      else          isr_q <= isr_q | evt_set;
      if (mask_we_i) mask_q <= wbyte_i;
    end
  end

  assign busy_o = ~sync_q[SYNC_STAGES-1];
  assign isr_o  = {{(8-EVT_BITS){1'b0}}, isr_q};
  assign mask_o = mask_q;
  assign irq_o  = mask_q[7] & |(isr_q & mask_q[EVT_BITS-1:0]);
endmodule

// File: rtl/nand_bridge.sv
module nand_bridge
  import nand_bridge_pkg::*;
#(
  parameter int         STROBE_CYC = 3,
  parameter logic [7:0] RESET_CMD  = 8'hFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        host_req_i,
  input  logic        host_we_i,
  input  logic        host_wide_i,
  input  logic [2:0]  host_addr_i,
  input  logic [15:0] host_wdata_i,
  output logic [15:0] host_rdata_o,
  output logic        host_wait_o,
  output logic        irq_o,
  output logic        nand_ce_no,
  output logic        nand_cle_o,
  output logic        nand_ale_o,
  output logic        nand_we_no,
  output logic        nand_re_no,
  output logic [7:0]  nand_dq_o,
  output logic        nand_dq_oe_o,
  input  logic [7:0]  nand_dq_i,
  input  logic        nand_rb_i
);
  top_st_e    st_q;
  logic       init_pend_q;
  logic [7:0] mode_q, rd_lo_q, rd_hi_q;
  logic       is_data, reg_access, eng_start, eng_wr, eng_done, force_cmd;
  logic [7:0] eng_wbyte, eng_rbyte, reg_rd, isr, mask;
  logic       busy;

  assign is_data    = (host_addr_i[2] == 1'b0);
  assign reg_access = host_req_i & ~is_data & (st_q == T_IDLE) & ~init_pend_q;
  assign host_wait_o = host_req_i & ~((st_q == T_DONE) | reg_access);

  assign eng_start = ((st_q == T_IDLE) & (init_pend_q | (host_req_i & is_data)))
                   | ((st_q == T_BYTE0) & eng_done & host_wide_i);
  assign eng_wr    = init_pend_q | host_we_i;
  assign eng_wbyte = init_pend_q ? RESET_CMD :
                     (st_q == T_BYTE0) ? host_wdata_i[15:8] : host_wdata_i[7:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= T_IDLE;
      init_pend_q <= 1'b1;
      mode_q      <= '0;
      rd_lo_q     <= '0;
      rd_hi_q     <= '0;
    end else begin
      unique case (st_q)
        T_IDLE: begin
          if (init_pend_q) st_q <= T_INIT;
          else if (host_req_i && is_data) st_q <= T_BYTE0;
          if (reg_access && host_we_i && host_addr_i == OFS_MODE)
            mode_q <= host_wdata_i[7:0];
        end
        T_INIT: if (eng_done) begin
          init_pend_q <= 1'b0;
          st_q        <= T_IDLE;
        end
        T_BYTE0: if (eng_done) begin
          rd_lo_q <= eng_rbyte;
          st_q    <= host_wide_i ? T_BYTE1 : T_DONE;
        end
        T_BYTE1: if (eng_done) begin
          rd_hi_q <= eng_rbyte;
          st_q    <= T_DONE;
        end
        default: st_q <= T_IDLE;
      endcase
    end
  end

  assign force_cmd  = (st_q == T_INIT);
  assign nand_ce_no = ~(mode_q[4] | force_cmd);
  assign nand_cle_o = mode_q[0] | force_cmd;
  assign nand_ale_o = mode_q[1] & ~force_cmd;

  always_comb begin
    unique case (host_addr_i)
      OFS_MODE:   reg_rd = mode_q;
      OFS_STATUS: reg_rd = {busy, 7'b0};
      OFS_ISR:    reg_rd = isr;
      OFS_MASK:   reg_rd = mask;
      default:    reg_rd = '0;
    endcase
  end

  assign host_rdata_o = !is_data    ? {8'h00, reg_rd} :
                        host_wide_i ? {rd_hi_q, rd_lo_q} : {8'h00, rd_lo_q};

  nand_byte_engine #(.STROBE_CYC(STROBE_CYC)) i_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (eng_start),
    .wr_i    (eng_wr),
    .wbyte_i (eng_wbyte),
    .done_o  (eng_done),
    .rbyte_o (eng_rbyte),
    .we_no   (nand_we_no),
    .re_no   (nand_re_no),
    .dq_o    (nand_dq_o),
    .dq_oe_o (nand_dq_oe_o),
    .dq_i    (nand_dq_i)
  );

  nand_irq_ctrl i_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rb_i      (nand_rb_i),
    .isr_we_i  (reg_access & host_we_i & (host_addr_i == OFS_ISR)),
    .mask_we_i (reg_access & host_we_i & (host_addr_i == OFS_MASK)),
    .wbyte_i   (host_wdata_i[7:0]),
    .busy_o    (busy),
    .isr_o     (isr),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/nand_bridge_chk.sv
module nand_bridge_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic host_req_i,
  input logic host_we_i,
  input logic host_wait_o,
  input logic irq_o,
  input logic nand_ce_no,
  input logic nand_cle_o,
  input logic nand_ale_o,
  input logic nand_we_no,
  input logic nand_re_no
);
  // R3
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nand_we_no && !nand_re_no));

  // R3
  latch_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no && $past(!nand_we_no)) |-> ($stable(nand_cle_o) && $stable(nand_ale_o)));

  // R2
  strobe_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no || !nand_re_no) |-> !nand_ce_no);

  // R10
  wait_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wait_o |-> host_req_i);

  // R9
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(irq_o) && !irq_o) |-> $past(host_req_i && host_we_i && !host_wait_o));
endmodule

bind nand_bridge nand_bridge_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .host_req_i  (host_req_i),
  .host_we_i   (host_we_i),
  .host_wait_o (host_wait_o),
  .irq_o       (irq_o),
  .nand_ce_no  (nand_ce_no),
  .nand_cle_o  (nand_cle_o),
  .nand_ale_o  (nand_ale_o),
  .nand_we_no  (nand_we_no),
  .nand_re_no  (nand_re_no)
);

// File: tb/test_nand_bridge.sv
`timescale 1ns/1ps
module test_nand_bridge;
  localparam int STROBE = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, wide = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        hwait, irq;
  logic        ce_n, cle, ale, we_n, re_n, dq_oe;
  logic [7:0]  dq_o, dq_i;
  logic        rb = 1'b1;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  nand_bridge #(.STROBE_CYC(STROBE)) i_nand_bridge (
    .clk_i(clk), .rst_ni(rst_n), .host_req_i(req), .host_we_i(we),
    .host_wide_i(wide), .host_addr_i(addr), .host_wdata_i(wdata),
    .host_rdata_o(rdata), .host_wait_o(hwait), .irq_o(irq),
    .nand_ce_no(ce_n), .nand_cle_o(cle), .nand_ale_o(ale),
    .nand_we_no(we_n), .nand_re_no(re_n), .nand_dq_o(dq_o),
    .nand_dq_oe_o(dq_oe), .nand_dq_i(dq_i), .nand_rb_i(rb)
  );

  // device model: write log and read source
  int         wr_cnt = 0;
  logic [7:0] log_dq [16];
  logic       log_cle [16];
  logic       log_ale [16];
  logic       log_ce_n [16];
  int         rd_idx = 0;
  int         we_cur = 0, we_w = 0, re_cur = 0, re_w = 0;

  function automatic logic [7:0] dev_byte(int i);
    return 8'h3C + 8'(i * 8'h37);
  endfunction

  assign dq_i = dev_byte(rd_idx);

  always @(posedge we_n) begin
    log_dq[wr_cnt % 16]   = dq_o;
    log_cle[wr_cnt % 16]  = cle;
    log_ale[wr_cnt % 16]  = ale;
    log_ce_n[wr_cnt % 16] = ce_n;
    wr_cnt = wr_cnt + 1;
  end
  always @(posedge re_n) rd_idx = rd_idx + 1;

  always @(negedge clk) begin
    if (we_n === 1'b0) we_cur = we_cur + 1;
    else if (we_cur != 0) begin we_w = we_cur; we_cur = 0; end
    if (re_n === 1'b0) re_cur = re_cur + 1;
    else if (re_cur != 0) begin re_w = re_cur; re_cur = 0; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host(input bit w, input bit wd, input logic [2:0] a,
                      input logic [15:0] d, output logic [15:0] rd, output bit waited);
    @(negedge clk);
    req = 1'b1; we = w; wide = wd; addr = a; wdata = d;
    waited = 1'b0;
    #1;
    while (hwait) begin
      waited = 1'b1;
      @(negedge clk);
      #1;
    end
    rd = rdata;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    logic [15:0] r; bit wt;
    host(1'b1, 1'b0, a, {8'h00, d}, r, wt);
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    logic [15:0] r; bit wt;
    host(1'b0, 1'b0, a, 16'h0, r, wt);
    d = r[7:0];
  endtask

  task automatic t_reset();
    int base;
    repeat (3) @(negedge clk);
    base = wr_cnt;
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(wr_cnt - base == 1, "R1 reset write count", wr_cnt - base, 1);
    chk(log_dq[base % 16] == 8'hFF && log_cle[base % 16] && !log_ale[base % 16] && !log_ce_n[base % 16],
        "R1 reset command", {log_ce_n[base % 16], log_ale[base % 16], log_cle[base % 16], log_dq[base % 16]}, 12'h1FF);
    chk(ce_n && !cle && !ale && we_n && re_n, "R1 standby pins", {ce_n, cle, ale}, 3'b100);
  endtask

  task automatic t_mode();
    logic [7:0] d;
    reg_wr(3'd4, 8'h95); reg_rd(3'd4, d);
    chk(d == 8'h95 && !ce_n && cle && !ale, "R2 command mode", {ce_n, cle, ale, d}, {3'b010, 8'h95});
    reg_wr(3'd4, 8'h96); reg_rd(3'd4, d);
    chk(d == 8'h96 && !ce_n && !cle && ale, "R2 address mode", {ce_n, cle, ale, d}, {3'b001, 8'h96});
    reg_wr(3'd4, 8'h94);
    chk(!ce_n && !cle && !ale, "R2 data mode", {ce_n, cle, ale}, 3'b000);
    reg_wr(3'd4, 8'h00);
    chk(ce_n && !cle && !ale, "R2 standby mode", {ce_n, cle, ale}, 3'b100);
  endtask

  task automatic t_write8();
    logic [15:0] r; bit wt; int base;
    reg_wr(3'd4, 8'h95);
    base = wr_cnt;
    host(1'b1, 1'b0, 3'd0, 16'h5570, r, wt);
    @(negedge clk);
    chk(wr_cnt - base == 1 && log_dq[base % 16] == 8'h70 && log_cle[base % 16] && !log_ale[base % 16],
        "R3 command byte", log_dq[base % 16], 8'h70);
    chk(we_w == STROBE, "R3 we width", we_w, STROBE);
    chk(wt, "R10 data write waits", wt, 1);
    reg_wr(3'd4, 8'h96);
    base = wr_cnt;
    host(1'b1, 1'b0, 3'd0, 16'h0012, r, wt);
    chk(log_dq[base % 16] == 8'h12 && log_ale[base % 16] && !log_cle[base % 16],
        "R3 address byte", {log_ale[base % 16], log_dq[base % 16]}, 9'h112);
  endtask

  task automatic t_write16();
    logic [15:0] r; bit wt; int base;
    reg_wr(3'd4, 8'h94);
    base = wr_cnt;
    host(1'b1, 1'b1, 3'd0, 16'hBEEF, r, wt);
    chk(wr_cnt - base == 2, "R4 two writes", wr_cnt - base, 2);
    chk(log_dq[base % 16] == 8'hEF && log_dq[(base + 1) % 16] == 8'hBE, "R4 lane order",
        {log_dq[base % 16], log_dq[(base + 1) % 16]}, 16'hEFBE);
  endtask

  task automatic t_read();
    logic [15:0] r, exp16; bit wt; int base;
    reg_wr(3'd4, 8'h94);
    base = rd_idx;
    exp16 = {dev_byte(base + 1), dev_byte(base)};
    host(1'b0, 1'b1, 3'd0, 16'h0, r, wt);
    chk(r == exp16, "R5 wide read", r, exp16);
    chk(re_w == STROBE, "R5 re width", re_w, STROBE);
    chk(wt, "R10 data read waits", wt, 1);
    exp16 = {8'h00, dev_byte(base + 2)};
    host(1'b0, 1'b0, 3'd0, 16'h0, r, wt);
    chk(r == exp16, "R5 narrow read", r, exp16);
    chk(rd_idx - base == 3, "R5 read pulse count", rd_idx - base, 3);
  endtask

  task automatic t_status();
    logic [15:0] r; bit wt;
    host(1'b0, 1'b0, 3'd5, 16'h0, r, wt);
    chk(r[7:0] == 8'h00, "R6 ready status", r[7:0], 8'h00);
    chk(!wt, "R10 register no wait", wt, 0);
    @(negedge clk); rb = 1'b0;
    repeat (5) @(negedge clk);
    host(1'b0, 1'b0, 3'd5, 16'h0, r, wt);
    chk(r[7:0] == 8'h80, "R6 busy status", r[7:0], 8'h80);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    reg_rd(3'd6, d);
    chk(d == 8'h00, "R7 no event on low level", d, 8'h00);
    @(negedge clk); rb = 1'b1;
    repeat (5) @(negedge clk);
    reg_rd(3'd6, d);
    chk(d == 8'h01, "R7 rising edge event", d, 8'h01);
    chk(!irq, "R9 masked off", irq, 0);
    reg_wr(3'd7, 8'h01);
    chk(!irq, "R9 no global enable", irq, 0);
    reg_wr(3'd7, 8'h81);
    chk(irq, "R9 enabled", irq, 1);
    repeat (4) @(negedge clk);
    chk(irq, "R9 stays asserted", irq, 1);
    reg_wr(3'd7, 8'h00);
    chk(!irq, "R9 mask removed", irq, 0);
    reg_wr(3'd7, 8'h81);
    reg_wr(3'd6, 8'h0F);
    reg_rd(3'd6, d);
    chk(d == 8'h00 && !irq, "R8 clear pending", {irq, d}, 0);
    @(negedge clk); rb = 1'b0;
    repeat (5) @(negedge clk);
    reg_rd(3'd6, d);
    chk(d == 8'h00 && !irq, "R7 falling edge ignored", {irq, d}, 0);
    @(negedge clk); rb = 1'b1;
    repeat (5) @(negedge clk);
    chk(irq, "R9 second event", irq, 1);
    reg_wr(3'd6, 8'h0F);
    chk(!irq, "R8 clear drops irq", irq, 0);
  endtask

  initial begin
    t_reset();
    t_mode();
    t_write8();
    t_write16();
    t_read();
    t_status();
    t_irq();
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule